// File: doc/BRIEF.md
# Buck Converter Protection Sequencer

This block is the supervisory state machine of a voltage-mode step-down regulator. It decides in every clock cycle whether the power stage may switch. It takes a digital enable, a sampled input-supply code, a sampled die-temperature code and an over-current flag. From these it produces three things: a permission to run the pulse-width modulator, a command that forces the low-side switch on to discharge the output, and a request to the reference ramp to perform a soft start. A run indication and a 3-bit phase code report where the sequencer stands.

Faults are ranked. A low enable beats everything. An input supply below the lockout level comes next, then over-temperature, then over-current. The supply and temperature inputs each pass through a registered hysteresis flag, so a code that hovers near a threshold cannot make the state chatter. Every start passes through a timed soft-start phase. An over-current event discharges the output for one millisecond, counted in clock cycles, and then restarts through soft start. If the fault persists, this cycle repeats.

Top module: `buck_prot_seq`

## Requirements
- R1: While reset is held and in the cycle after its release, the phase code is 0 (off) and every output is low.
- R2: A low enable moves the sequencer to phase 0 at the next clock edge from any phase, and both switch outputs drop low.
- R3: With enable high, the sequencer stays in phase 1 (lockout) until the supply code reaches UV_RISE or more; a code of UV_RISE-1 keeps it locked out.
- R4: Once the supply is qualified, only a code below UV_RISE-UV_HYST returns the sequencer to lockout; a code equal to UV_RISE-UV_HYST keeps it running.
- R5: Every start enters phase 2 (soft start) for exactly SS_CYCLES cycles, with ss_req_o and hs_allow_o high. It then enters phase 3 (run), with run_ok_o and hs_allow_o high. Phase 3 is reached only from phase 2.
- R6: An over-current flag sampled high in soft start or run moves the sequencer to phase 4 (hiccup) at the next edge: hs_allow_o goes low and ls_force_o goes high.
- R7: Phase 4 lasts exactly CLK_HZ/1000 cycles and is followed by phase 2. If over-current persists, soft start leads straight back to phase 4 for another full hold.
- R8: A temperature code above OT_TRIP moves the sequencer to phase 5 (thermal off), with both switch outputs low. A code equal to OT_TRIP does not trip it.
- R9: Phase 5 is left only once the temperature code falls to OT_TRIP-OT_HYST or below, and the exit goes through phase 2.
- R10: Priority is enable, then lockout, then thermal, then over-current. A higher fault overrides a lower phase, including a hold in progress, and a hold entered later always lasts its full length.
- R11: hs_allow_o and ls_force_o are never high in the same cycle.
- R12: Phase codes are 0 off, 1 lockout, 2 soft start, 3 run, 4 hiccup, 5 thermal off. The outputs are decoded from the phase alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable, high to run |
| vin_code_i | input | VIN_W | Sampled input-supply code |
| tj_code_i | input | TEMP_W | Sampled junction-temperature code |
| ocp_i | input | 1 | Over-current flag from the current comparator |
| hs_allow_o | output | 1 | Modulator may switch (high-side permitted) |
| ls_force_o | output | 1 | Force low-side switch on (discharge) |
| ss_req_o | output | 1 | Soft-start request to the reference ramp |
| run_ok_o | output | 1 | Regulator in steady run |
| phase_o | output | 3 | Current phase code |

## Verification
The hardest situation to reach is an over-current hold that is cut short by a higher fault and then entered again. The bench has to show that the second hold restarts from zero rather than resuming, and the hold counter is not visible at the ports. To get there, the stimulus keeps the over-current flag high and pulses enable low partway through a hold. It then counts the cycles of the next hold at the phase output and expects the full length. The same persistent flag, combined with rising temperature and a falling supply code, walks the sequencer down the priority ladder while a hold is in progress.

// File: rtl/buck_seq_pkg.sv
// Shared types for the buck protection sequencer.
// Assumes: phase encoding is visible at the top-level port and stays fixed.
package buck_seq_pkg;
    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_LOCK   = 3'd1,
        PH_SOFT   = 3'd2,
        PH_RUN    = 3'd3,
        PH_HICCUP = 3'd4,
        PH_HOT    = 3'd5
    } seq_phase_e;
endpackage

// File: rtl/hyst_flag.sv
// Registered hysteresis flag: sets when the code reaches SET_AT and clears
// when the code drops below CLR_BELOW. Between the two levels it holds.
// Assumes: CLR_BELOW <= SET_AT and the code is already synchronous to clk.
module hyst_flag #(
    parameter int W         = 8,
    parameter int SET_AT    = 110,
    parameter int CLR_BELOW = 103
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_i,
    output logic         flag_o
);
    localparam logic [W-1:0] SET_LVL = W'(SET_AT);
    localparam logic [W-1:0] CLR_LVL = W'(CLR_BELOW);

    // Update the flag at the edges of the hysteresis band, else hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_o <= 1'b0;
        else if (code_i >= SET_LVL)  flag_o <= 1'b1;
        else if (code_i <  CLR_LVL)  flag_o <= 1'b0;
    end

    // Inside the band the flag never changes.
    assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i < SET_LVL && code_i >= CLR_LVL) |=> $stable(flag_o));
endmodule

// File: rtl/phase_timer.sv
// Phase duration counter shared by soft start and the hiccup hold.
// Restarts from zero when the sequencer changes phase and saturates.
// Assumes: both windows are at least one cycle long.
module phase_timer #(
    parameter int HOLD_CYC = 50000,
    parameter int SS_CYC   = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic sel_hold_i,
    output logic expired_o
);
    localparam int MAX_CYC = (HOLD_CYC > SS_CYC) ? HOLD_CYC : SS_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SS_LAST   = CW'(SS_CYC - 1);
    localparam logic [CW-1:0] CNT_TOP   = CW'(MAX_CYC);

    logic [CW-1:0] cnt;

    // Count cycles spent in the current phase, clearing on each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt <= '0;
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end

    // Select the terminal count of the window in use.
    always_comb expired_o = (cnt == (sel_hold_i ? HOLD_LAST : SS_LAST));

    // A hold never counts past its last cycle.
    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hold_i && !restart_i) |-> (cnt <= HOLD_LAST));
endmodule

// File: rtl/seq_fsm.sv
// Ranked fault state machine for the buck power stage.
// Assumes: qualified supply and thermal flags arrive registered, enable and
// over-current are synchronous to clk, timer expiry refers to this phase.
module seq_fsm
    import buck_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       vin_ok_i,
    input  logic       hot_i,
    input  logic       ocp_i,
    input  logic       expired_i,
    output seq_phase_e phase_o,
    output logic       restart_o,
    output logic       sel_hold_o
);
    seq_phase_e nxt;

    // Pick the next phase: ranked faults first, then the phase's own flow.
    always_comb begin
        nxt = phase_o;
        if (!en_i)          nxt = PH_OFF;
        else if (!vin_ok_i) nxt = PH_LOCK;
        else if (hot_i)     nxt = PH_HOT;
        else begin
            unique case (phase_o)
                PH_OFF, PH_LOCK, PH_HOT: nxt = PH_SOFT;
                PH_SOFT:   if (ocp_i) nxt = PH_HICCUP;
                           else if (expired_i) nxt = PH_RUN;
                PH_RUN:    if (ocp_i) nxt = PH_HICCUP;
                PH_HICCUP: if (expired_i) nxt = PH_SOFT;
                default:   nxt = PH_OFF;
            endcase
        end
    end

    // Hold the current phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_OFF;
        else        phase_o <= nxt;
    end

    // Tell the timer when a new phase begins and which window applies.
    always_comb begin
        restart_o  = (nxt != phase_o);
        sel_hold_o = (phase_o == PH_HICCUP);
    end

    assert_enable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (phase_o == PH_OFF));

    assert_run_via_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_RUN && $past(phase_o) != PH_RUN) |-> ($past(phase_o) == PH_SOFT));

    assert_hiccup_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_o) == PH_HICCUP && phase_o != PH_HICCUP &&
         $past(en_i) && $past(vin_ok_i) && !$past(hot_i)) |-> (phase_o == PH_SOFT));

    assert_thermal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_HOT && hot_i && en_i && vin_ok_i) |=> (phase_o == PH_HOT));

    assert_lockout_rank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !vin_ok_i) |=> (phase_o == PH_LOCK));
endmodule

// File: rtl/buck_prot_seq.sv
// Top of the buck protection sequencer: qualifies supply and temperature
// with hysteresis, runs the ranked phase machine and decodes permissions.
// Assumes: all inputs are synchronous to clk; the codes rise with voltage
// and with temperature respectively.
module buck_prot_seq
    import buck_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int VIN_W     = 8,
    parameter int UV_RISE   = 110,
    parameter int UV_HYST   = 7,
    parameter int TEMP_W    = 8,
    parameter int OT_TRIP   = 150,
    parameter int OT_HYST   = 15,
    parameter int SS_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [VIN_W-1:0]  vin_code_i,
    input  logic [TEMP_W-1:0] tj_code_i,
    input  logic              ocp_i,
    output logic              hs_allow_o,
    output logic              ls_force_o,
    output logic              ss_req_o,
    output logic              run_ok_o,
    output logic [2:0]        phase_o
);
    localparam int HOLD_CYC  = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int UV_CLR    = UV_RISE - UV_HYST;
    localparam int OT_SET    = OT_TRIP + 1;
    localparam int OT_CLR    = OT_TRIP - OT_HYST + 1;

    logic       vin_ok, hot, expired, restart, sel_hold;
    seq_phase_e phase;

    hyst_flag #(.W(VIN_W), .SET_AT(UV_RISE), .CLR_BELOW(UV_CLR)) u_uv_flag (
        .clk(clk), .rst_n(rst_n), .code_i(vin_code_i), .flag_o(vin_ok));

    hyst_flag #(.W(TEMP_W), .SET_AT(OT_SET), .CLR_BELOW(OT_CLR)) u_ot_flag (
        .clk(clk), .rst_n(rst_n), .code_i(tj_code_i), .flag_o(hot));

    phase_timer #(.HOLD_CYC(HOLD_CYC), .SS_CYC(SS_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .sel_hold_i(sel_hold), .expired_o(expired));

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .vin_ok_i(vin_ok),
        .hot_i(hot), .ocp_i(ocp_i), .expired_i(expired),
        .phase_o(phase), .restart_o(restart), .sel_hold_o(sel_hold));

    // Decode the stage permissions from the phase alone.
    always_comb begin
        hs_allow_o = (phase == PH_SOFT) || (phase == PH_RUN);
        ls_force_o = (phase == PH_HICCUP);
        ss_req_o   = (phase == PH_SOFT);
        run_ok_o   = (phase == PH_RUN);
        phase_o    = phase;
    end

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_allow_o && ls_force_o));

    assert_hiccup_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o == 3'd3 || phase_o == 3'd2) && ocp_i && en_i && vin_ok && !hot)
        |=> (ls_force_o && !hs_allow_o));

    assert_thermal_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && vin_ok && hot) |=> (!hs_allow_o && !ls_force_o));
endmodule

// File: tb/buck_prot_seq_bench.sv
module buck_prot_seq_bench;
    localparam int CLK_HZ = 20000;
    localparam int HOLD   = CLK_HZ / 1000;
    localparam int SS     = 12;

    logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, ocp = 1'b0;
    logic [7:0] vin = 8'd0, tj = 8'd25;
    logic       hs, ls, ssr, rok;
    logic [2:0] ph;

    buck_prot_seq #(.CLK_HZ(CLK_HZ), .UV_RISE(110), .UV_HYST(7),
                    .OT_TRIP(150), .OT_HYST(15), .SS_CYCLES(SS)) u_buck_prot_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .vin_code_i(vin), .tj_code_i(tj),
        .ocp_i(ocp), .hs_allow_o(hs), .ls_force_o(ls), .ss_req_o(ssr),
        .run_ok_o(rok), .phase_o(ph));

    always #10 clk = ~clk;

    typedef struct { logic [2:0] st; string tag; } exp_t;
    exp_t sbq[$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Monitor: pop expected phases and compare all outputs against the R12 map.
    initial forever begin
        exp_t it;
        logic [6:0] act, exp;
        wait (sbq.size() > 0);
        #1;
        it  = sbq.pop_front();
        act = {ph, hs, ls, ssr, rok};
        exp = {it.st, (it.st == 3'd2 || it.st == 3'd3), (it.st == 3'd4),
               (it.st == 3'd2), (it.st == 3'd3)};
        checks++;
        if (act !== exp || (hs && ls)) begin
            errors++;
            $display("FAIL %s (R11/R12 map): actual {ph,hs,ls,ss,run}=%b expected %b",
                     it.tag, act, exp);
        end
    end

    task automatic expect_ph(input logic [2:0] st, input string tag);
        exp_t it;
        it.st = st; it.tag = tag;
        sbq.push_back(it);
        #2;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count consecutive cycles spent in a phase, starting from its first cycle.
    task automatic measure(input logic [2:0] st, input int exp, input string tag);
        int n = 0;
        while (ph == st && n < 5000) begin n++; step(1); end
        check_val(n, exp, tag);
    endtask

    task automatic reach_run();
        int n = 0;
        while (ph != 3'd3 && n < 5000) begin n++; step(1); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_ph(3'd0, "R1 in reset");
        rst_n = 1'b1;
        step(1);
        expect_ph(3'd0, "R1 after release");

        en = 1'b1; vin = 8'd100;
        step(4); expect_ph(3'd1, "R3 low supply locks out");
        vin = 8'd109;
        step(4); expect_ph(3'd1, "R3 one below rise");
        vin = 8'd110;
        step(2); expect_ph(3'd2, "R5 soft start on rise");
        measure(3'd2, SS, "R5 soft start length");
        expect_ph(3'd3, "R5 run after soft start");

        vin = 8'd103;
        step(4); expect_ph(3'd3, "R4 at hysteresis floor stays");
        vin = 8'd102;
        step(2); expect_ph(3'd1, "R4 below floor locks out");
        vin = 8'd110;
        reach_run();

        ocp = 1'b1; step(1); ocp = 1'b0;
        expect_ph(3'd4, "R6 over-current discharge");
        measure(3'd4, HOLD, "R7 hold length");
        expect_ph(3'd2, "R7 soft start after hold");
        reach_run();
        ocp = 1'b1; step(1);
        expect_ph(3'd4, "R7 persistent first hold");
        measure(3'd4, HOLD, "R7 persistent hold length");
        expect_ph(3'd2, "R7 restart soft start");
        step(1);
        expect_ph(3'd4, "R7 repeats hiccup");
        measure(3'd4, HOLD, "R7 second hold length");
        ocp = 1'b0;
        reach_run();

        tj = 8'd150;
        step(4); expect_ph(3'd3, "R8 at trip no shutdown");
        tj = 8'd151;
        step(2); expect_ph(3'd5, "R8 above trip");
        tj = 8'd136;
        step(4); expect_ph(3'd5, "R9 not cooled enough");
        tj = 8'd135;
        step(2); expect_ph(3'd2, "R9 restart via soft start");
        reach_run();

        ocp = 1'b1; step(1);
        expect_ph(3'd4, "R10 hold entered");
        step(3);
        tj = 8'd160;
        step(2); expect_ph(3'd5, "R10 thermal beats hold");
        vin = 8'd90;
        step(2); expect_ph(3'd1, "R10 lockout beats thermal");
        en = 1'b0;
        step(1); expect_ph(3'd0, "R2 enable beats lockout");
        en = 1'b1;
        step(1); expect_ph(3'd1, "R10 lockout after enable");
        vin = 8'd120;
        step(2); expect_ph(3'd5, "R10 still hot");
        tj = 8'd25;
        step(2); expect_ph(3'd2, "R10 cooled to soft start");
        step(1); expect_ph(3'd4, "R10 over-current again");
        step(5);
        en = 1'b0;
        step(1); expect_ph(3'd0, "R2 enable cuts hold");
        en = 1'b1;
        step(1); expect_ph(3'd2, "R5 soft start after enable");
        step(1);
        measure(3'd4, HOLD, "R10 fresh full hold");
        ocp = 1'b0;
        reach_run();

        vin = 8'd102; step(2);
        vin = 8'd110; step(2);
        expect_ph(3'd2, "R5 soft start again");
        step(3);
        en = 1'b0;
        step(1); expect_ph(3'd0, "R2 enable cuts soft start");

        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule